// File: doc/BRIEF.md
# Branch Target and Link Generator

This block works out where the program counter goes after a branch and what, if anything, goes into the link register. Each cycle it may accept one branch. The branch is described by a kind, a displacement, an absolute-addressing flag, a link flag and a taken decision that has already been made elsewhere. The block also reads the current link and count register values. One clock later it presents the next instruction address, a link write enable and the value to write.

Immediate branches come in two reaches. The long form is unconditional and carries a 24-bit word offset. The short form is conditional and carries a 14-bit word offset. Either displacement can be added to the current address or, when the absolute flag is set, used as the address itself. Indirect branches take their target from the count register or from the link register, aligned to a word. Linking stores the address of the following instruction, whatever the branch outcome. When a branch through the link register also links, the jump uses the link value held before the write.

Top module: `branch_target_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid`, `lr_we`, `next_pc` and `lr_wdata` are all zero.
- R2: With `kind` = 2'b00 (long immediate) and `is_abs` = 0, `next_pc` = `cur_pc` + 4 × sign-extended `disp[23:0]`, modulo 2^32. The `taken` input has no effect for this kind.
- R3: With `kind` = 2'b01 (short conditional immediate), `taken` = 1 and `is_abs` = 0, `next_pc` = `cur_pc` + 4 × sign-extended `disp[13:0]`. Bits `disp[23:14]` are ignored.
- R4: With `is_abs` = 1, the immediate kinds use 4 × the sign-extended displacement directly as `next_pc`, without adding `cur_pc`. For the short kind, this puts targets in the lowest or highest 32 KB.
- R5: With `kind` = 2'b10 (count register target) and `taken` = 1, `next_pc` = `ctr_val` with bits [1:0] cleared. `disp` and `is_abs` are ignored.
- R6: With `kind` = 2'b11 (link register target) and `taken` = 1, `next_pc` = `lr_val` with bits [1:0] cleared. When `do_link` = 1, this is the link value presented with the branch, not the value being written.
- R7: For kinds 2'b01, 2'b10 and 2'b11 with `taken` = 0, `next_pc` = `cur_pc` + 4.
- R8: When `in_valid` = 1 and `do_link` = 1, the next cycle has `lr_we` = 1 and `lr_wdata` = `cur_pc` + 4. This holds whether or not the branch is taken.
- R9: Results appear exactly one clock after `in_valid` is sampled high. After a cycle with `in_valid` = 0, `out_valid` and `lr_we` are 0 and `next_pc` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A branch is presented this cycle |
| cur_pc | input | 32 | Address of the branch instruction |
| disp | input | 24 | Word displacement; the short kind uses bits [13:0] |
| is_abs | input | 1 | Treat the displacement as an absolute address |
| do_link | input | 1 | Write the return address into the link register |
| kind | input | 2 | 00 long imm, 01 short cond imm, 10 via count, 11 via link |
| taken | input | 1 | Branch decision for the conditional kinds |
| lr_val | input | 32 | Current link register value |
| ctr_val | input | 32 | Current count register value |
| out_valid | output | 1 | Registered result is valid |
| next_pc | output | 32 | Next instruction address |
| lr_we | output | 1 | Link register write enable |
| lr_wdata | output | 32 | Value for the link register |

## Verification
The two functions that can fall in the same cycle are the read of the link register as a jump target and the write of a new return address into it. The bench triggers this with a link-register-target branch that also links, using an old link value that differs from `cur_pc` + 4 and has nonzero low bits. It then checks that `next_pc` equals the old value with its low bits cleared, while `lr_we` and `lr_wdata` carry the new return address in that same output cycle. A not-taken conditional branch with linking is also run, to confirm that the write still occurs while the address only steps forward.

// File: rtl/btg_pkg.sv
package btg_pkg;
  typedef enum logic [1:0] {
    BK_LONG_IMM  = 2'b00,
    BK_SHORT_IMM = 2'b01,
    BK_VIA_CTR   = 2'b10,
    BK_VIA_LR    = 2'b11
  } btg_kind_e;
endpackage

// File: rtl/btg_imm_target.sv
module btg_imm_target #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 24
) (
  input  logic [ADDR_W-1:0] base_pc,
  input  logic [DISP_W-1:0] word_off,
  input  logic              absolute,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - DISP_W - 2;

  logic [ADDR_W-1:0] byte_off;

  // word offset becomes a sign-extended byte offset
  assign byte_off = {{EXT_W{word_off[DISP_W-1]}}, word_off, 2'b00};
  assign target   = absolute ? byte_off : (base_pc + byte_off);
endmodule

// File: rtl/btg_reg_target.sv
module btg_reg_target #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] count_reg,
  input  logic [ADDR_W-1:0] link_reg,
  input  logic              use_link,
  output logic [ADDR_W-1:0] target
);
  logic [ADDR_W-1:0] picked;

  assign picked = use_link ? link_reg : count_reg;
  assign target = {picked[ADDR_W-1:2], 2'b00};
endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen #(
  parameter int ADDR_W       = 32,
  parameter int LONG_DISP_W  = 24,
  parameter int SHORT_DISP_W = 14,
  parameter int INSN_BYTES   = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [ADDR_W-1:0]      cur_pc,
  input  logic [LONG_DISP_W-1:0] disp,
  input  logic                   is_abs,
  input  logic                   do_link,
  input  logic [1:0]             kind,
  input  logic                   taken,
  input  logic [ADDR_W-1:0]      lr_val,
  input  logic [ADDR_W-1:0]      ctr_val,
  output logic                   out_valid,
  output logic [ADDR_W-1:0]      next_pc,
  output logic                   lr_we,
  output logic [ADDR_W-1:0]      lr_wdata
);
  import btg_pkg::*;

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  btg_kind_e         kind_e;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] long_tgt;
  logic [ADDR_W-1:0] short_tgt;
  logic [ADDR_W-1:0] reg_tgt;
  logic              go;
  logic [ADDR_W-1:0] pc_d;

  assign kind_e = btg_kind_e'(kind);
  assign seq_pc = cur_pc + STEP;

  btg_imm_target #(.ADDR_W(ADDR_W), .DISP_W(LONG_DISP_W)) u_long (
    .base_pc (cur_pc),
    .word_off(disp),
    .absolute(is_abs),
    .target  (long_tgt)
  );

  btg_imm_target #(.ADDR_W(ADDR_W), .DISP_W(SHORT_DISP_W)) u_short (
    .base_pc (cur_pc),
    .word_off(disp[SHORT_DISP_W-1:0]),
    .absolute(is_abs),
    .target  (short_tgt)
  );

  // the link operand is the value presented now, before any write lands
  btg_reg_target #(.ADDR_W(ADDR_W)) u_reg (
    .count_reg(ctr_val),
    .link_reg (lr_val),
    .use_link (kind_e == BK_VIA_LR),
    .target   (reg_tgt)
  );

  always_comb begin
    go = (kind_e == BK_LONG_IMM) | taken;
    case (kind_e)
      BK_LONG_IMM:  pc_d = long_tgt;
      BK_SHORT_IMM: pc_d = short_tgt;
      default:      pc_d = reg_tgt;
    endcase
    if (!go) pc_d = seq_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      next_pc   <= '0;
      lr_we     <= 1'b0;
      lr_wdata  <= '0;
    end else begin
      out_valid <= in_valid;
      lr_we     <= in_valid & do_link;
      if (in_valid) begin
        next_pc  <= pc_d;
        lr_wdata <= seq_pc;
      end
    end
  end

  AST_LINK_WRITE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && do_link) |=> (lr_we && lr_wdata == $past(cur_pc) + STEP)); // R8

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind != 2'b00 && !taken) |=> (next_pc == $past(cur_pc) + STEP)); // R7

  AST_CTR_TARGET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind == 2'b10 && taken) |=> (next_pc == {$past(ctr_val[ADDR_W-1:2]), 2'b00})); // R5

  AST_LR_OLD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind == 2'b11 && taken) |=> (next_pc == {$past(lr_val[ADDR_W-1:2]), 2'b00})); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !lr_we && $stable(next_pc))); // R9
endmodule

// File: tb/branch_target_gen_bench.sv
module branch_target_gen_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] cur_pc;
  logic [23:0] disp;
  logic        is_abs;
  logic        do_link;
  logic [1:0]  kind;
  logic        taken;
  logic [31:0] lr_val;
  logic [31:0] ctr_val;
  logic        out_valid;
  logic [31:0] next_pc;
  logic        lr_we;
  logic [31:0] lr_wdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  branch_target_gen u_branch_target_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cur_pc(cur_pc), .disp(disp),
    .is_abs(is_abs), .do_link(do_link), .kind(kind), .taken(taken),
    .lr_val(lr_val), .ctr_val(ctr_val), .out_valid(out_valid),
    .next_pc(next_pc), .lr_we(lr_we), .lr_wdata(lr_wdata)
  );

  function automatic int bytes_long(input logic [23:0] d);
    int w = int'(d);
    if (d[23]) w = w - (1 << 24);
    return w * 4;
  endfunction

  function automatic int bytes_short(input logic [13:0] d);
    int w = int'(d);
    if (d[13]) w = w - (1 << 14);
    return w * 4;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] pc, input logic [23:0] d, input logic ab,
                       input logic lk, input logic [1:0] k, input logic tk,
                       input logic [31:0] lr, input logic [31:0] ctr);
    @(negedge clk);
    in_valid = 1'b1; cur_pc = pc; disp = d; is_abs = ab; do_link = lk;
    kind = k; taken = tk; lr_val = lr; ctr_val = ctr;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; cur_pc = 32'h1234; disp = '0; is_abs = 0;
    do_link = 1; kind = 0; taken = 1; lr_val = '0; ctr_val = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1", "lr_we", {31'd0, lr_we}, 32'd0);
    chk("R1", "next_pc", next_pc, 32'd0);
    chk("R1", "lr_wdata", lr_wdata, 32'd0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1", "out_valid after release", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_long();
    issue(32'h0010_0000, 24'h000010, 0, 0, 2'b00, 1, 0, 0);
    chk("R2", "long forward", next_pc, 32'h0010_0000 + 32'(bytes_long(24'h000010)));
    chk("R9", "out_valid", {31'd0, out_valid}, 32'd1);
    chk("R8", "no link lr_we", {31'd0, lr_we}, 32'd0);
    issue(32'h0010_0000, 24'hFFFFF0, 0, 0, 2'b00, 0, 0, 0);
    chk("R2", "long backward, taken ignored", next_pc, 32'h000F_FFC0);
    issue(32'h0000_0008, 24'h800000, 0, 0, 2'b00, 1, 0, 0);
    chk("R2", "long most negative wraps", next_pc, 32'h0000_0008 + 32'(bytes_long(24'h800000)));
    issue(32'h0400_0000, 24'h7FFFFF, 0, 0, 2'b00, 1, 0, 0);
    chk("R2", "long most positive", next_pc, 32'h05FF_FFFC);
  endtask

  task automatic t_short();
    issue(32'h0000_2000, 24'h000040, 0, 0, 2'b01, 1, 0, 0);
    chk("R3", "short forward", next_pc, 32'h0000_2100);
    issue(32'h0000_2000, 24'hABC000 | 24'h003FFF, 0, 0, 2'b01, 1, 0, 0);
    chk("R3", "short upper disp bits ignored", next_pc, 32'h0000_2000 + 32'(bytes_short(14'h3FFF)));
  endtask

  task automatic t_absolute();
    issue(32'h1234_5678, 24'h000100, 1, 0, 2'b00, 1, 0, 0);
    chk("R4", "long absolute", next_pc, 32'h0000_0400);
    issue(32'h1234_5678, 24'h002000, 1, 0, 2'b01, 1, 0, 0);
    chk("R4", "short absolute top region", next_pc, 32'hFFFF_8000);
    issue(32'h1234_5678, 24'h001FFF, 1, 0, 2'b01, 1, 0, 0);
    chk("R4", "short absolute bottom region", next_pc, 32'h0000_7FFC);
  endtask

  task automatic t_ctr();
    issue(32'h0000_1000, 24'h123456, 1, 0, 2'b10, 1, 32'hDEAD_0000, 32'h8000_1237);
    chk("R5", "ctr target aligned, disp/abs ignored", next_pc, 32'h8000_1234);
    issue(32'h0000_1000, 24'h000000, 0, 0, 2'b10, 0, 32'hDEAD_0000, 32'h8000_1237);
    chk("R7", "ctr not taken", next_pc, 32'h0000_1004);
  endtask

  task automatic t_lr_link_same_cycle();
    issue(32'h0000_3000, 24'h0, 0, 1, 2'b11, 1, 32'h0040_0A03, 32'h0);
    chk("R6", "old lr used as target", next_pc, 32'h0040_0A00);
    chk("R8", "lr_we with lr target", {31'd0, lr_we}, 32'd1);
    chk("R8", "lr_wdata return address", lr_wdata, 32'h0000_3004);
  endtask

  task automatic t_not_taken_link();
    issue(32'h0000_5000, 24'h000100, 0, 1, 2'b01, 0, 32'h1111_1110, 0);
    chk("R7", "short not taken", next_pc, 32'h0000_5004);
    chk("R8", "link on fall-through lr_we", {31'd0, lr_we}, 32'd1);
    chk("R8", "link on fall-through data", lr_wdata, 32'h0000_5004);
    issue(32'hFFFF_FFFC, 24'h0, 0, 0, 2'b11, 0, 32'h0, 0);
    chk("R7", "fall-through wraps", next_pc, 32'h0000_0000);
  endtask

  task automatic t_idle();
    issue(32'h0000_7000, 24'h000004, 0, 1, 2'b00, 1, 0, 0);
    chk("R2", "before idle", next_pc, 32'h0000_7010);
    @(negedge clk);
    in_valid = 1'b0; cur_pc = 32'hFFFF_0000; do_link = 1;
    @(posedge clk); #1;
    chk("R9", "idle out_valid", {31'd0, out_valid}, 32'd0);
    chk("R9", "idle lr_we", {31'd0, lr_we}, 32'd0);
    chk("R9", "idle next_pc held", next_pc, 32'h0000_7010);
  endtask

  logic done = 1'b0;

  initial begin
    t_reset();
    t_long();
    t_short();
    t_absolute();
    t_ctr();
    t_lr_link_same_cycle();
    t_not_taken_link();
    t_idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule